// File: doc/BRIEF.md
# Sign-Sign Dual-Loop Equalizer Adaptation Engine

This block adapts a serial-link equalizer using the error bit from a single extra sampler whose threshold is set to a reference level. Each received symbol brings a data decision and an error bit that says whether the signal was above or below that level. Two coupled sign-sign loops run on these bits. One moves the reference level toward the true signal amplitude. The other nudges each equalizer tap weight by the product of the error sign and the sign of the decision that tap multiplies. Each loop has its own rate divider, so the two loops can run at different relative speeds.

For an unrolled one-tap decision-feedback receiver, the engine can restrict both loops to two-symbol decision patterns. In the high phase it learns the level of a repeated positive symbol, which is one plus the post-cursor. In the low phase it learns the level of a negative symbol that follows a positive one, which is one minus the post-cursor. Half the difference between the two learned levels is reported as the post-cursor offset. Whenever the sum of tap magnitudes exceeds a programmed transmit peak limit, the engine shrinks the taps toward zero, one step per cycle, until the limit is met.

Top module: `ssa_adapt_engine`

## Requirements
- R1: In normal mode (mode=0), on each accepted symbol the high reference level steps by +1 when e_n=1 and by -1 when e_n=0, but only when d_n=1. Here d_n and e_n are the decision and error bit given with the previous accepted symbol, because the one pre-cursor tap makes the symbol under adaptation lag the newest by one. A decision of 1 means positive. An error bit of 1 means the signal was above the level.
- R2: Tap j (0 = pre-cursor, 1 = main, 2 and 3 = post-cursors) steps by +1 when e_n equals the decision j-1 symbols before d_n, and by -1 otherwise. Tap 0 pairs with the newest decision. Tap j occupies bits [8j+7:8j] of taps_out. In mode 0 every accepted symbol is a tap update event.
- R3: The reference levels and tap weights are two's complement and saturate at +127 and -128 without wrapping.
- R4: In mode 1 both loops take an event only when (d_n, d_{n-1}) = (1,1). Level updates go to the high level.
- R5: In mode 2 both loops take an event only when (d_n, d_{n-1}) = (0,1). Level updates go to the low level. dlev_out shows the low level in mode 2 and the high level in every other mode.
- R6: alpha_out equals floor((high level - low level) / 2).
- R7: Each loop applies an update on every (div+1)-th qualifying event, counting from reset. The level loop uses lev_div and the tap loop uses eq_div, and the two counters are independent.
- R8: In any cycle where the sum of tap magnitudes exceeds peak_lim, every nonzero tap moves one LSB toward zero and tap updates are withheld. Shrinking stops once the sum is at or below the limit.
- R9: Neither loop changes state in a cycle without sym_valid, or in mode 3.
- R10: After reset both levels are 32, alpha is 0, the main tap is 64 and the other taps are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol's decision and error bit are present |
| dec_in | input | 1 | Data decision, 1 = positive |
| err_in | input | 1 | Error sampler bit, 1 = above the reference level |
| mode | input | 2 | 0 normal, 1 high-pattern phase, 2 low-pattern phase, 3 hold |
| lev_div | input | 4 | Level loop rate divider |
| eq_div | input | 4 | Tap loop rate divider |
| peak_lim | input | 10 | Limit on the sum of tap magnitudes |
| dlev_out | output | 8 | Active reference level for the error sampler |
| alpha_out | output | 8 | Learned post-cursor offset |
| taps_out | output | 32 | Four packed signed tap weights |

## Verification
The bench drives both loops to each saturation limit. A wrapping adder would show the level or a tap jumping from +127 to -128, or from -128 to +127. Pattern gating is checked by counting events: off-by-one gating makes the high level differ by one from the value the count predicts, and the wrong phase updates the wrong level. A divider that fires on the wrong event or shares one counter between both loops produces level and tap values that do not match the fired-event counts. Peak scaling is checked with a negative tap, which would grow instead of shrink if the sign were ignored, and with symbols arriving during scaling, which would let a tap update slip through.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_PR_HIGH = 2'd1,
        MODE_PR_LOW  = 2'd2,
        MODE_HOLD    = 2'd3
    } adapt_mode_e;
endpackage

// File: rtl/ssa_sat_step.sv
// Saturating signed +/- STEP (R3).
module ssa_sat_step #(
    parameter int W    = 8,
    parameter int STEP = 1
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic signed [W:0] HI     = $signed({2'b00, {(W-1){1'b1}}});
    localparam logic signed [W:0] LO     = $signed({2'b11, {(W-1){1'b0}}});
    localparam logic signed [W:0] STEP_E = $signed((W+1)'(STEP));

    logic signed [W:0] ext_d;
    logic signed [W:0] sum_d;

    assign ext_d = $signed({cur[W-1], cur});
    assign sum_d = up ? (ext_d + STEP_E) : (ext_d - STEP_E);

    always_comb begin
        if (sum_d > HI)      nxt = HI[W-1:0];
        else if (sum_d < LO) nxt = LO[W-1:0];
        else                 nxt = sum_d[W-1:0];
    end
endmodule

// File: rtl/ssa_rate_div.sv
// Fires on every (div+1)-th event (R7).
module ssa_rate_div #(
    parameter int DIVW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            event_in,
    input  logic [DIVW-1:0] div,
    output logic            fire
);
    logic [DIVW-1:0] cnt_d, cnt_q;

    assign fire = event_in && (cnt_q >= div);

    always_comb begin
        cnt_d = cnt_q;
        if (event_in) cnt_d = fire ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ssa_l1_over.sv
// Sum of tap magnitudes compared with the peak limit (R8).
module ssa_l1_over #(
    parameter int NTAP = 4,
    parameter int WW   = 8,
    parameter int SW   = 10
) (
    input  logic [NTAP-1:0][WW-1:0] taps,
    input  logic [SW-1:0]           limit,
    output logic                    over
);
    logic [SW-1:0] sum_d;

    always_comb begin
        sum_d = '0;
        for (int j = 0; j < NTAP; j++) begin
            if (taps[j][WW-1]) sum_d = sum_d + SW'(~taps[j] + 1'b1);
            else               sum_d = sum_d + SW'(taps[j]);
        end
        over = sum_d > limit;
    end
endmodule

// File: rtl/ssa_adapt_engine.sv
module ssa_adapt_engine
    import ssa_pkg::*;
#(
    parameter int NTAP      = 4,
    parameter int PRE       = 1,
    parameter int WW        = 8,
    parameter int LW        = 8,
    parameter int DIVW      = 4,
    parameter int LEV_STEP  = 1,
    parameter int TAP_STEP  = 1,
    parameter int MAIN_INIT = 64,
    parameter int LEV_INIT  = 32,
    localparam int SW       = WW + $clog2(NTAP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_valid,
    input  logic               dec_in,
    input  logic               err_in,
    input  logic [1:0]         mode,
    input  logic [DIVW-1:0]    lev_div,
    input  logic [DIVW-1:0]    eq_div,
    input  logic [SW-1:0]      peak_lim,
    output logic [LW-1:0]      dlev_out,
    output logic [LW-1:0]      alpha_out,
    output logic [NTAP*WW-1:0] taps_out
);
    typedef struct packed {
        logic [NTAP-2:0]           dec_hist;
        logic [PRE-1:0]            err_hist;
        logic [LW-1:0]             lev_hi;
        logic [LW-1:0]             lev_lo;
        logic [NTAP-1:0][WW-1:0]   taps;
    } state_t;

    state_t st_d, st_q;

    adapt_mode_e           mode_e;
    logic [NTAP-1:0]       win;
    logic [PRE:0]          errw;
    logic                  d_n, d_n1, e_n;
    logic                  lev_gate, eq_gate;
    logic                  lev_event, eq_event, lev_fire, eq_fire;
    logic                  over;
    logic [LW-1:0]         lev_cur, lev_next;
    logic [NTAP-1:0][WW-1:0] tap_next;
    logic [LW:0]           lev_diff;

    assign mode_e = adapt_mode_e'(mode);

    // Decision window: win[0] is the newest decision, tap j pairs with win[j].
    always_comb begin
        win[0]  = dec_in;
        errw[0] = err_in;
        for (int i = 1; i < NTAP; i++) win[i]  = st_q.dec_hist[i-1];
        for (int i = 1; i <= PRE; i++) errw[i] = st_q.err_hist[i-1];
    end

    assign d_n  = win[PRE];
    assign d_n1 = win[PRE+1];
    assign e_n  = errw[PRE];

    always_comb begin
        unique case (mode_e)
            MODE_NORMAL:  begin lev_gate = d_n;          eq_gate = 1'b1;         end
            MODE_PR_HIGH: begin lev_gate = d_n & d_n1;   eq_gate = d_n & d_n1;   end
            MODE_PR_LOW:  begin lev_gate = ~d_n & d_n1;  eq_gate = ~d_n & d_n1;  end
            default:      begin lev_gate = 1'b0;         eq_gate = 1'b0;         end
        endcase
    end

    ssa_l1_over #(.NTAP(NTAP), .WW(WW), .SW(SW)) u_over (
        .taps(st_q.taps), .limit(peak_lim), .over(over)
    );

    assign lev_event = sym_valid & lev_gate;
    assign eq_event  = sym_valid & eq_gate & ~over;

    ssa_rate_div #(.DIVW(DIVW)) u_lev_div (
        .clk(clk), .rst_n(rst_n), .event_in(lev_event), .div(lev_div), .fire(lev_fire)
    );
    ssa_rate_div #(.DIVW(DIVW)) u_eq_div (
        .clk(clk), .rst_n(rst_n), .event_in(eq_event), .div(eq_div), .fire(eq_fire)
    );

    assign lev_cur = (mode_e == MODE_PR_LOW) ? st_q.lev_lo : st_q.lev_hi;

    ssa_sat_step #(.W(LW), .STEP(LEV_STEP)) u_lev_step (
        .cur(lev_cur), .up(e_n), .nxt(lev_next)
    );

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        ssa_sat_step #(.W(WW), .STEP(TAP_STEP)) u_tap_step (
            .cur(st_q.taps[g]), .up(e_n == win[g]), .nxt(tap_next[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (sym_valid) begin
            st_d.dec_hist[0] = dec_in;
            st_d.err_hist[0] = err_in;
            for (int i = 1; i < NTAP-1; i++) st_d.dec_hist[i] = st_q.dec_hist[i-1];
            for (int i = 1; i < PRE; i++)    st_d.err_hist[i] = st_q.err_hist[i-1];
        end
        if (lev_fire) begin
            if (mode_e == MODE_PR_LOW) st_d.lev_lo = lev_next;
            else                       st_d.lev_hi = lev_next;
        end
        if (over) begin
            for (int j = 0; j < NTAP; j++) begin
                if (st_q.taps[j][WW-1])      st_d.taps[j] = st_q.taps[j] + 1'b1;
                else if (st_q.taps[j] != '0) st_d.taps[j] = st_q.taps[j] - 1'b1;
            end
        end else if (eq_fire) begin
            st_d.taps = tap_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.lev_hi   <= LW'(LEV_INIT);
            st_q.lev_lo   <= LW'(LEV_INIT);
            st_q.taps[PRE] <= WW'(MAIN_INIT);
        end else begin
            st_q <= st_d;
        end
    end

    assign lev_diff  = {st_q.lev_hi[LW-1], st_q.lev_hi} - {st_q.lev_lo[LW-1], st_q.lev_lo};
    assign alpha_out = lev_diff[LW:1];
    assign dlev_out  = lev_cur;
    assign taps_out  = st_q.taps;
endmodule

// File: rtl/ssa_adapt_checker.sv
module ssa_adapt_checker #(
    parameter int NTAP = 4,
    parameter int WW   = 8,
    parameter int LW   = 8,
    parameter int SW   = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sym_valid,
    input logic [1:0]         mode,
    input logic [SW-1:0]      peak_lim,
    input logic [LW-1:0]      dlev_out,
    input logic [LW-1:0]      alpha_out,
    input logic [NTAP*WW-1:0] taps_out
);
    localparam logic [LW-1:0] LMAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] LMIN = {1'b1, {(LW-1){1'b0}}};

    logic [SW-1:0] l1;
    logic          over_c;

    always_comb begin
        l1 = '0;
        for (int j = 0; j < NTAP; j++) begin
            logic signed [WW-1:0] t;
            t = $signed(taps_out[j*WW +: WW]);
            l1 = l1 + SW'(t < 0 ? -t : t);
        end
        over_c = l1 > peak_lim;
    end

    assert_taps_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !over_c) |=> $stable(taps_out));

    assert_hold_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !over_c) |=> $stable(taps_out));

    assert_scale_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        over_c |=> (l1 < $past(l1)));

    assert_dlev_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> (!$stable(mode) || $stable(dlev_out)));

    assert_alpha_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(alpha_out));

    assert_no_wrap_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dlev_out == LMAX) |=> (!$stable(mode) || dlev_out != LMIN));

    assert_no_wrap_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dlev_out == LMIN) |=> (!$stable(mode) || dlev_out != LMAX));
endmodule

bind ssa_adapt_engine ssa_adapt_checker #(
    .NTAP(NTAP), .WW(WW), .LW(LW), .SW(SW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .mode(mode),
    .peak_lim(peak_lim), .dlev_out(dlev_out), .alpha_out(alpha_out),
    .taps_out(taps_out)
);

// File: tb/tb_ssa_adapt_engine.sv
`timescale 1ns/1ps
module tb_ssa_adapt_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic        dec_in = 1'b0;
    logic        err_in = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [3:0]  lev_div = 4'd0;
    logic [3:0]  eq_div = 4'd0;
    logic [9:0]  peak_lim = 10'd1023;
    logic [7:0]  dlev_out;
    logic [7:0]  alpha_out;
    logic [31:0] taps_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ssa_adapt_engine dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .dec_in(dec_in),
        .err_in(err_in), .mode(mode), .lev_div(lev_div), .eq_div(eq_div),
        .peak_lim(peak_lim), .dlev_out(dlev_out), .alpha_out(alpha_out),
        .taps_out(taps_out)
    );

    // {dec, err, dlev, tap0, tap1, tap2, tap3}, mode 0, from reset
    localparam logic [41:0] VEC [4] = '{
        {1'b1, 1'b1, 8'sd32, -8'sd1, 8'sd65, 8'sd1,  8'sd1},
        {1'b1, 1'b0, 8'sd33, 8'sd0,  8'sd66, 8'sd0,  8'sd0},
        {1'b0, 1'b1, 8'sd32, 8'sd1,  8'sd65, -8'sd1, 8'sd1},
        {1'b0, 1'b0, 8'sd32, 8'sd0,  8'sd64, 8'sd0,  8'sd2}
    };

    function automatic int tap(input int j);
        return int'($signed(taps_out[j*8 +: 8]));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [9:0] lim);
        rst_n = 1'b0; sym_valid = 1'b0; mode = 2'd0;
        lev_div = 4'd0; eq_div = 4'd0; peak_lim = lim;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic apply(input logic d, input logic e);
        sym_valid = 1'b1; dec_in = d; err_in = e;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(10'd1023);
        // R10 reset state
        check("R10 dlev", $signed(dlev_out), 32);
        check("R10 alpha", $signed(alpha_out), 0);
        check("R10 tap0", tap(0), 0);
        check("R10 tap1", tap(1), 64);
        check("R10 tap3", tap(3), 0);

        // R1/R2 vector table
        foreach (VEC[i]) begin
            apply(VEC[i][41], VEC[i][40]);
            check("R1 table dlev", $signed(dlev_out), int'($signed(VEC[i][39:32])));
            for (int j = 0; j < 4; j++)
                check("R2 table tap", tap(j), int'($signed(VEC[i][31-8*j -: 8])));
        end

        // R9 hold mode and idle cycles
        mode = 2'd3;
        for (int k = 0; k < 3; k++) apply(1'b1, 1'b1);
        check("R9 hold dlev", $signed(dlev_out), 32);
        check("R9 hold tap3", tap(3), 2);
        mode = 2'd0;
        dec_in = 1'b1; err_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 idle dlev", $signed(dlev_out), 32);
        check("R9 idle tap1", tap(1), 64);

        // R3 upward saturation, then R5/R6 low phase
        do_reset(10'd1023);
        for (int k = 0; k < 200; k++) apply(1'b1, 1'b1);
        check("R3 dlev max", $signed(dlev_out), 127);
        for (int j = 0; j < 4; j++) check("R3 tap max", tap(j), 127);
        check("R6 alpha hi", $signed(alpha_out), 47);
        mode = 2'd2;
        @(negedge clk);
        check("R5 low level shown", $signed(dlev_out), 32);
        for (int k = 0; k < 400; k++) apply(k[0] ? 1'b0 : 1'b1, 1'b0);
        check("R5 low level min", $signed(dlev_out), -128);
        check("R6 alpha full", $signed(alpha_out), 127);
        mode = 2'd1;
        @(negedge clk);
        check("R5 high level kept", $signed(dlev_out), 127);

        // R3 downward saturation
        do_reset(10'd1023);
        for (int k = 0; k < 200; k++) apply(1'b1, 1'b0);
        check("R3 dlev min", $signed(dlev_out), -128);
        for (int j = 0; j < 4; j++) check("R3 tap min", tap(j), -128);

        // R4 high-pattern gating
        do_reset(10'd1023);
        mode = 2'd1;
        for (int k = 0; k < 10; k++) apply(1'b1, 1'b1);
        check("R4 high level", $signed(dlev_out), 40);
        check("R6 alpha", $signed(alpha_out), 4);

        // R1 normal gating count for comparison
        do_reset(10'd1023);
        for (int k = 0; k < 10; k++) apply(1'b1, 1'b1);
        check("R1 normal gating", $signed(dlev_out), 41);

        // R7 independent dividers
        do_reset(10'd1023);
        lev_div = 4'd2; eq_div = 4'd2;
        for (int k = 0; k < 10; k++) apply(1'b1, 1'b1);
        check("R7 dlev div", $signed(dlev_out), 35);
        check("R7 tap0 div", tap(0), 3);
        check("R7 tap1 div", tap(1), 67);
        check("R7 tap3 div", tap(3), 1);

        // R8 scaling toward zero with a negative tap
        do_reset(10'd1023);
        apply(1'b1, 1'b1);
        peak_lim = 10'd64;
        repeat (3) @(negedge clk);
        check("R8 neg tap shrunk", tap(0), 0);
        check("R8 main tap", tap(1), 64);
        check("R8 tap3", tap(3), 0);

        // R8 tap updates withheld while over the limit
        do_reset(10'd60);
        apply(1'b1, 1'b1);
        apply(1'b1, 1'b1);
        check("R8 main shrinking", tap(1), 62);
        check("R8 no tap update", tap(0), 0);
        check("R8 level still runs", $signed(dlev_out), 33);
        repeat (5) @(negedge clk);
        check("R8 settles at limit", tap(1), 60);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule